// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four active-low modem control inputs of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them to the host as one read-only status byte. Each pin is first brought into the clock domain through a synchronizer. The upper nibble of the byte shows the current asserted state of each line. The lower nibble holds sticky change indications that the host collects by reading.

Three of the change indications latch on any transition of their line. The ring-indicator indication latches only when the ring pin returns high, which marks the end of a ring burst. A read of the status byte clears all four indications. A change that lands in the same cycle as the read is kept, so no event is lost. An interrupt request is raised while any indication is set and the host has enabled modem-status interrupts. When no modem is attached, the four lines serve as general-purpose inputs with change detection.

Top module: `modem_status_detect`

## Requirements
- R1: After reset, with all four pins held high (inactive), the status byte reads 0x00 and the interrupt output is 0.
- R2: Status bits 4, 5, 6 and 7 show the inverted level of pins 0 (clear-to-send), 1 (data-set-ready), 2 (ring) and 3 (carrier detect). A pin change shows up on the port after SYNC_STAGES rising clock edges.
- R3: Status bits 0, 1 and 3 latch to 1 on a rising or falling transition of pins 0, 1 and 3. The bit is set on the edge after the synchronized level changes, which is SYNC_STAGES+1 edges after the pin changes.
- R4: Status bit 2 latches only on a 0-to-1 transition of the ring pin (pin 2). A 1-to-0 transition leaves it unchanged.
- R5: A cycle with the read strobe high clears all four change bits at the following clock edge.
- R6: If a change bit is set in the same cycle as a read strobe, the set takes priority and the bit reads 1 afterwards.
- R7: The interrupt output equals the enable input ANDed with the OR of status bits 0 to 3, with no register delay.
- R8: A change bit that is set stays set until a read strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modem_n_i | input | 4 | Active-low pins: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier detect |
| rd_stb_i | input | 1 | Host read strobe for the status byte, one cycle per read |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | [3:0] change flags, [7:4] inverted synchronized pin levels |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its defaults: SYNC_STAGES of 2 and a rising-only mask that selects the ring line alone. This sets an exact three-edge latency from pin to flag, so the bench can place a read strobe on the very edge where a flag sets and check the priority rule. The directed cases cover both edge directions on the ring line. The random phase toggles several pins at once with reads and enable changes mixed in.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int unsigned N_LINES = 4;
  localparam int unsigned STATUS_W = 2 * N_LINES;

  typedef enum logic [1:0] {
    LINE_CTS = 2'd0,
    LINE_DSR = 2'd1,
    LINE_RI  = 2'd2,
    LINE_CD  = 2'd3
  } line_e;

  localparam logic [N_LINES-1:0] DEFAULT_RISE_ONLY = 4'b0100;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RESET_VAL;
    else        chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RESET_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/msd_edge.sv
module msd_edge #(
  parameter bit RISE_ONLY = 1'b0,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic event_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RESET_VAL;
    else        level_q <= level_i;
  end

  if (RISE_ONLY) begin : g_rise
    assign event_o = level_i & ~level_q;
  end else begin : g_any
    assign event_o = level_i ^ level_q;
  end
endmodule

// File: rtl/msd_flags.sv
module msd_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_i) flags_d = '0;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] RISE_ONLY_MASK = DEFAULT_RISE_ONLY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  modem_n_i,
  input  logic                rd_stb_i,
  input  logic                msi_en_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o
);
  logic [N_LINES-1:0] pins_sync;
  logic [N_LINES-1:0] line_event;
  logic [N_LINES-1:0] delta_flags;

  msd_sync #(
    .WIDTH    (N_LINES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({N_LINES{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (modem_n_i),
    .q_o  (pins_sync)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    msd_edge #(
      .RISE_ONLY(RISE_ONLY_MASK[i]),
      .RESET_VAL(1'b1)
    ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(pins_sync[i]),
      .event_o(line_event[i])
    );
  end

  msd_flags #(
    .WIDTH(N_LINES)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (line_event),
    .clr_i  (rd_stb_i),
    .flags_o(delta_flags)
  );

  assign status_o = {~pins_sync, delta_flags};
  assign irq_o    = msi_en_i & (|delta_flags);
endmodule

// File: rtl/modem_status_detect_chk.sv
module modem_status_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb_i,
  input logic       msi_en_i,
  input logic [7:0] status_o,
  input logic       irq_o
);
  // R8: without a read, no set flag drops
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

  // R7: interrupt follows enable and flags
  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en_i && (status_o[3:0] != 4'h0)) |-> irq_o);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en_i || (status_o[3:0] == 4'h0)) |-> !irq_o);

  // R3: a clear-to-send flag rise follows a level change one edge earlier
  p_cts_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> ($past(status_o[4]) != $past(status_o[4], 2)));

  // R4: the ring flag rises only after the ring pin went high
  p_ri_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> (!$past(status_o[6]) && $past(status_o[6], 2)));
endmodule

bind modem_status_detect modem_status_detect_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_stb_i(rd_stb_i),
  .msi_en_i(msi_en_i),
  .status_o(status_o),
  .irq_o   (irq_o)
);

// File: tb/tb_modem_status_detect.sv
module tb_modem_status_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] modem_n_i = 4'hF;
  logic       rd_stb_i = 1'b0;
  logic       msi_en_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_s0 = 4'hF, m_s1 = 4'hF, m_prev = 4'hF, m_flags = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_detect dut (
    .clk(clk), .rst_n(rst_n), .modem_n_i(modem_n_i),
    .rd_stb_i(rd_stb_i), .msi_en_i(msi_en_i),
    .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [3:0] events(input logic [3:0] cur, input logic [3:0] old);
    logic [3:0] e;
    e = cur ^ old;
    e[2] = cur[2] & ~old[2];
    return e;
  endfunction

  function automatic logic [7:0] exp_status();
    return {~m_s1, m_flags};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    m_flags = events(m_s1, m_prev) | (m_flags & ~{4{rd_stb_i}});
    m_prev = m_s1;
    m_s1 = m_s0;
    m_s0 = modem_n_i;
    #1;
    chk("R2 level nibble", {28'h0, status_o[7:4]}, {28'h0, exp_status() >> 4});
    chk("R3 change nibble", {28'h0, status_o[3:0]}, {28'h0, m_flags});
    chk("R7 irq", {31'h0, irq_o}, {31'h0, msi_en_i & (|m_flags)});
  endtask

  task automatic drive(input logic [3:0] p, input logic rd, input logic en);
    @(negedge clk);
    modem_n_i = p;
    rd_stb_i = rd;
    msi_en_i = en;
  endtask

  task automatic clear_all();
    drive(modem_n_i, 1'b1, msi_en_i);
    cyc();
    drive(modem_n_i, 1'b0, msi_en_i);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", {24'h0, status_o}, 32'h0);
    chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R1 idle status", {24'h0, status_o}, 32'h0);

    // R2 and R3: clear-to-send falls, level shows after 2 edges, flag after 3
    drive(4'hE, 1'b0, 1'b1);
    cyc();
    chk("R2 not yet", {31'h0, status_o[4]}, 32'h0);
    cyc();
    chk("R2 level after two edges", {31'h0, status_o[4]}, 32'h1);
    chk("R3 flag not yet", {31'h0, status_o[0]}, 32'h0);
    cyc();
    chk("R3 flag after three edges", {31'h0, status_o[0]}, 32'h1);
    chk("R7 irq raised", {31'h0, irq_o}, 32'h1);
    repeat (4) cyc();
    chk("R8 flag held", {31'h0, status_o[0]}, 32'h1);
    drive(4'hE, 1'b0, 1'b0);
    #1;
    chk("R7 irq drops with enable", {31'h0, irq_o}, 32'h0);
    drive(4'hE, 1'b1, 1'b1);
    cyc();
    chk("R5 read clears", {28'h0, status_o[3:0]}, 32'h0);
    chk("R7 irq drops with flags", {31'h0, irq_o}, 32'h0);
    drive(4'hE, 1'b0, 1'b1);

    // R4: ring falling edge gives no flag, rising edge does
    drive(4'hA, 1'b0, 1'b1);
    repeat (5) cyc();
    chk("R4 ring start no flag", {31'h0, status_o[2]}, 32'h0);
    chk("R4 ring level", {31'h0, status_o[6]}, 32'h1);
    drive(4'hE, 1'b0, 1'b1);
    repeat (3) cyc();
    chk("R4 ring end flag", {31'h0, status_o[2]}, 32'h1);
    clear_all();

    // R6: carrier detect change lands on the read cycle
    drive(4'h6, 1'b0, 1'b1);
    cyc();
    cyc();
    drive(4'h6, 1'b1, 1'b1);
    cyc();
    chk("R6 set wins over read", {31'h0, status_o[3]}, 32'h1);
    drive(4'h6, 1'b0, 1'b1);
    cyc();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] p;
      p = modem_n_i;
      if ($urandom_range(0, 3) == 0) p = p ^ 4'($urandom_range(1, 15));
      drive(p, ($urandom_range(0, 4) == 0), ($urandom_range(0, 7) != 0));
      cyc();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule